// File: doc/BRIEF.md
# Chained-Descriptor Audio Transfer Channel

This block is one transfer channel that streams audio samples between a contiguous memory buffer and a single fixed peripheral data register. Work is described by link descriptors kept in memory. Each descriptor names a source, a destination, a byte count and the address of the next descriptor. One descriptor is one segment, and software normally sizes a segment to one audio period. A chain whose last link points back to its first keeps the channel cycling through the buffer without software help. A next pointer with bit 0 set ends the chain.

Software programs the mode word and the first descriptor address through a small register port. It then starts the channel, either by writing the mode word or by letting the peripheral raise a start request. On every beat the channel reads one hold-sized unit from the source and writes it to the destination. The peripheral side keeps a fixed address, and the memory side advances. Data moves in bandwidth chunks, and between chunks the peripheral can stall the channel with a pause input. Segment ends, the end of the chain and errors are reported through status bits and a single interrupt line.

Top module: `audio_dma_chan`

## Requirements
- R1: A descriptor is fetched from the descriptor address register (reg_addr 2) as 32-bit reads. The source address is at byte offset 4, the destination address at 12, the next pointer at 20 and the byte count at 28. The words at offsets 0, 8, 16 and 24 are not used.
- R2: Each beat reads 2^hold bytes from the source and then writes them to the destination. The hold field is mode bits 9:8, and mem_size carries the same value. After a beat that does not end the segment, each side whose hold enable is clear (mode bit 6 for the source, bit 7 for the destination) advances by 2^hold. A side whose hold enable is set keeps its address.
- R3: A segment ends on the beat that takes the remaining count to zero or below. If the segment interrupt enable (mode bit 2) is set, the segment-done status bit (status bit 3) is then set and irq is raised.
- R4: When a segment ends and its next pointer has bit 0 set, the channel sets the chain-end status bit (status bit 4) and goes idle. The chain-end bit raises irq under mode bit 2.
- R5: When a segment ends and its next pointer has bit 0 clear, the channel loads that pointer as the descriptor address and fetches the next descriptor. A chain that links back to its first descriptor therefore repeats the buffer indefinitely.
- R6: The chunk size is 2^bw bytes, where bw is mode bits 13:10. Before each chunk and at each segment start, if the pause enable (mode bit 5) is set and ext_pause is high, the channel waits and issues no memory access.
- R7: When the external start enable (mode bit 4) is set, a kick (mode write with bit 0 set) does not start the channel. The channel starts instead while ext_req is high.
- R8: The programming-error bit (status bit 1) is set and the channel stops in either of two cases: a fetched descriptor has a byte count of zero, or a start is attempted with the pause enable set while the count register (reg_addr 3) is non-zero.
- R9: A memory response with mem_err set sets the transfer-error bit (status bit 0) and halts the channel.
- R10: irq reflects the transfer-error and programming-error bits only while the error interrupt enable (mode bit 3) is set.
- R11: Writing 1 to a status bit clears it. Writing all ones clears every clearable status bit.
- R12: A mode write with bit 1 (abort) set stops the channel in the next cycle. No start is accepted while the stored abort bit remains set.
- R13: Status bit 2 (busy) is high from the start of the descriptor fetch until the channel goes idle. While the channel is busy, writes to the descriptor address and count registers are ignored.
- R14: The live source (reg_addr 4) and destination (reg_addr 5) registers show the address of the most recent beat. After a segment ends they show the address of its last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_size | output | 2 | Access size as log2 of bytes |
| mem_wdata | output | DW | Write data, low bytes used |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| mem_rdata | input | DW | Read data, valid with mem_ack |
| ext_req | input | 1 | Peripheral start request |
| ext_pause | input | 1 | Peripheral pause between chunks |
| irq | output | 1 | Interrupt |

## Verification
The embedded properties check, on every cycle, that:
- the held-side address stays fixed between beats;
- the remaining count falls by exactly one hold unit per beat;
- an abort or a failed access leaves the channel idle one cycle later;
- a zero count raises the programming error;
- a terminated chain sets the chain-end bit;
- the channel issues no access while paused.

Only the directed scenarios can show behaviour that spans a whole run: that the peripheral receives the buffer's samples in order and wraps across a looping chain, that pausing stalls only at chunk boundaries, that external start and the enable gates on irq behave as specified, and that the live address registers end on the last beat.

// File: rtl/audio_dma_chan.sv
module audio_dma_chan #(
  parameter int AW = 32,
  parameter int DW = 64,
  parameter int CW = 32
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic          mem_err,
  input  logic [DW-1:0] mem_rdata,
  input  logic          ext_req,
  input  logic          ext_pause,
  output logic          irq
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_GATE, S_RD, S_WR} st_t;

  st_t            st;
  logic [13:0]    mode;
  logic [AW-1:0]  cur, nxt, s_addr, d_addr;
  logic [CW-1:0]  cnt, chunk;
  logic [DW-1:0]  buf_q;
  logic [1:0]     widx;
  logic           te, pe, eos, eoc;

  wire            mode_we  = reg_we && reg_addr == 3'd0;
  wire            kick     = mode_we && reg_wdata[0];
  wire            abort_w  = mode_we && reg_wdata[1];
  wire            nx_abort = mode_we ? reg_wdata[1] : mode[1];
  wire            nx_ems   = mode_we ? reg_wdata[4] : mode[4];
  wire            nx_emp   = mode_we ? reg_wdata[5] : mode[5];
  wire [1:0]      hsz      = mode[9:8];
  wire [CW-1:0]   sz_b     = CW'(1) << hsz;
  wire [CW-1:0]   chunk_b  = CW'(1) << mode[13:10];
  wire [CW-1:0]   chunk_n  = chunk + sz_b;
  wire            last     = cnt <= sz_b;
  wire            busy     = st != S_IDLE;
  wire            start_ok = !busy && !nx_abort && (nx_ems ? ext_req : kick);
  wire [31:0]     rword    = mem_rdata[31:0];

  assign mem_wdata = buf_q;
  assign irq = (mode[2] & (eos | eoc)) | (mode[3] & (te | pe));

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur + AW'({widx, 3'b100});
    mem_size = 2'd2;
    case (st)
      S_FETCH: mem_req = 1'b1;
      S_RD:    begin mem_req = 1'b1; mem_addr = s_addr; mem_size = hsz; end
      S_WR:    begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = d_addr; mem_size = hsz; end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = 32'(mode);
      3'd1:    reg_rdata = {27'b0, eoc, eos, busy, pe, te};
      3'd2:    reg_rdata = 32'(cur);
      3'd3:    reg_rdata = 32'(cnt);
      3'd4:    reg_rdata = 32'(s_addr);
      3'd5:    reg_rdata = 32'(d_addr);
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; mode <= '0; cur <= '0; nxt <= '0; s_addr <= '0; d_addr <= '0;
      cnt <= '0; chunk <= '0; buf_q <= '0; widx <= '0;
      te <= 1'b0; pe <= 1'b0; eos <= 1'b0; eoc <= 1'b0;
    end else begin
      if (mode_we) mode <= reg_wdata[13:0];
      if (reg_we && reg_addr == 3'd1) begin
        te  <= te  & ~reg_wdata[0];
        pe  <= pe  & ~reg_wdata[1];
        eos <= eos & ~reg_wdata[3];
        eoc <= eoc & ~reg_wdata[4];
      end
      if (reg_we && reg_addr == 3'd2 && !busy) cur <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == 3'd3 && !busy) cnt <= reg_wdata[CW-1:0];
      if (abort_w) st <= S_IDLE;
      else case (st)
        S_IDLE: if (start_ok) begin
          if (nx_emp && cnt != '0) pe <= 1'b1;
          else begin st <= S_FETCH; widx <= '0; end
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin te <= 1'b1; st <= S_IDLE; end
          else begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: s_addr <= AW'(rword);
              2'd1: d_addr <= AW'(rword);
              2'd2: nxt    <= AW'(rword);
              default: begin
                cnt <= CW'(rword);
                if (rword == '0) begin pe <= 1'b1; st <= S_IDLE; end
                else begin chunk <= '0; st <= S_GATE; end
              end
            endcase
          end
        end
        S_GATE: if (!(mode[5] && ext_pause)) st <= S_RD;
        S_RD: if (mem_ack) begin
          if (mem_err) begin te <= 1'b1; st <= S_IDLE; end
          else begin buf_q <= mem_rdata; st <= S_WR; end
        end
        S_WR: if (mem_ack) begin
          if (mem_err) begin te <= 1'b1; st <= S_IDLE; end
          else if (last) begin
            cnt <= '0;
            chunk <= '0;
            if (mode[2]) eos <= 1'b1;
            if (nxt[0]) begin eoc <= 1'b1; st <= S_IDLE; end
            else begin cur <= {nxt[AW-1:1], 1'b0}; widx <= '0; st <= S_FETCH; end
          end else begin
            cnt <= cnt - sz_b;
            if (!mode[6]) s_addr <= s_addr + AW'(sz_b);
            if (!mode[7]) d_addr <= d_addr + AW'(sz_b);
            if (chunk_n >= chunk_b) begin chunk <= '0; st <= S_GATE; end
            else begin chunk <= chunk_n; st <= S_RD; end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ack && !mem_err && !abort_w && !last && mode[6]) |=> $stable(s_addr));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ack && !mem_err && !abort_w && !last) |=> cnt == $past(cnt) - $past(sz_b));

  p_chain_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && mem_ack && !mem_err && !abort_w && last && nxt[0]) |=> (eoc && st == S_IDLE));

  p_pause_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_GATE && mode[5] && ext_pause && !abort_w) |=> !mem_req);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && mem_ack && !mem_err && !abort_w && widx == 2'd3 && rword == '0) |=> (pe && st == S_IDLE));

  p_err_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !abort_w) |=> (te && st == S_IDLE));

  p_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    abort_w |=> (st == S_IDLE && !mem_req));
endmodule

// File: tb/sim_audio_dma_chan.sv
module sim_audio_dma_chan;
  localparam int CLK_P = 10;
  localparam logic [31:0] PER = 32'h3F0;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [31:0] reg_wdata = '0; logic [31:0] reg_rdata;
  logic mem_req, mem_we; logic [31:0] mem_addr; logic [1:0] mem_size; logic [63:0] mem_wdata;
  logic mem_ack = 1'b0, mem_err = 1'b0; logic [63:0] mem_rdata = '0;
  logic ext_req = 1'b0, ext_pause = 1'b0; logic irq;

  audio_dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .mem_rdata(mem_rdata), .ext_req(ext_req), .ext_pause(ext_pause), .irq(irq));

  logic [7:0]  mem [0:1023];
  logic [63:0] plog [0:511];
  int          nlog = 0;
  logic [7:0]  pcnt = 8'h40;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic        tb_we = 1'b0; logic [31:0] tb_a = '0, tb_d = '0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    logic [63:0] t;
    if (tb_we) for (int k = 0; k < 4; k++) mem[10'(tb_a + k)] <= tb_d[8*k +: 8];
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_err <= (mem_addr == err_addr);
      if (mem_we) begin
        if (mem_addr == PER) begin plog[nlog % 512] <= mem_wdata; nlog <= nlog + 1; end
        else for (int k = 0; k < 8; k++) if (k < (1 << mem_size)) mem[10'(mem_addr + k)] <= mem_wdata[8*k +: 8];
      end else if (mem_addr == PER) begin
        mem_rdata <= {56'b0, pcnt}; pcnt <= pcnt + 8'd1;
      end else begin
        t = '0;
        for (int k = 0; k < 8; k++) if (k < (1 << mem_size)) t[8*k +: 8] = mem[10'(mem_addr + k)];
        mem_rdata <= t;
      end
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0;
    end
  end

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); tb_we = 1'b1; tb_a = a; tb_d = d;
    @(negedge clk); tb_we = 1'b0;
  endtask
  task automatic desc(input logic [31:0] b, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] n, input logic [31:0] c);
    poke(b + 4, s); poke(b + 12, d); poke(b + 20, n); poke(b + 28, c);
  endtask
  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin rd(3'd1, s); if (!s[2]) break; end
  endtask
  task automatic wait_log(input int n);
    for (int i = 0; i < 3000; i++) begin if (nlog >= n) break; tick(1); end
  endtask
  function automatic logic [31:0] md(input bit kick, input bit ab, input bit sie, input bit eie,
      input bit ems, input bit emp, input bit sh, input bit dh, input logic [1:0] hs, input logic [3:0] bw);
    return {18'b0, bw, hs, dh, sh, emp, ems, eie, sie, ab, kick};
  endfunction

  task automatic t_reset();
    logic [31:0] s;
    rd(3'd1, s);
    chk("R13 status after reset", s, 0);
    chk("R13 irq after reset", irq, 0);
    chk("R13 no request after reset", mem_req, 0);
  endtask

  task automatic t_playback();
    logic [31:0] s; int base, bad;
    for (int i = 0; i < 4; i++)
      poke(32'h100 + 4*i, {8'(8'h13 + 4*i), 8'(8'h12 + 4*i), 8'(8'h11 + 4*i), 8'(8'h10 + 4*i)});
    desc(32'h000, 32'h100, PER, 32'h020, 8);
    desc(32'h020, 32'h108, PER, 32'h000, 8);
    wr(3'd2, 32'h000);
    base = nlog;
    wr(3'd0, md(1, 0, 1, 0, 0, 0, 0, 1, 2'd1, 4'd4));
    wait_log(base + 12);
    wr(3'd0, md(0, 1, 1, 0, 0, 0, 0, 1, 2'd1, 4'd4));
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      int j = k % 8;
      if (plog[(base + k) % 512][15:0] !== {8'(8'h11 + 2*j), 8'(8'h10 + 2*j)}) bad++;
    end
    chk("R1 R2 R5 sample order with wrap", bad, 0);
    rd(3'd1, s);
    chk("R3 segment-done bit", s[3], 1);
    chk("R3 irq on segment end", irq, 1);
    chk("R12 busy clear after abort", s[2], 0);
    chk("R12 no request after abort", mem_req, 0);
    wr(3'd0, md(1, 1, 1, 0, 0, 0, 0, 1, 2'd1, 4'd4));
    rd(3'd1, s);
    chk("R12 kick ignored while abort set", s[2], 0);
    wr(3'd1, 32'h8);
    rd(3'd1, s);
    chk("R11 segment bit cleared by write-1", s[3], 0);
    chk("R11 irq drops after clear", irq, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_capture();
    logic [31:0] s, a; logic [7:0] p0; int bad;
    desc(32'h040, PER, 32'h200, 32'h041, 6);
    wr(3'd2, 32'h040);
    p0 = pcnt;
    wr(3'd0, md(1, 0, 1, 0, 0, 0, 1, 0, 2'd0, 4'd2));
    wait_idle();
    bad = 0;
    for (int i = 0; i < 6; i++) if (mem[10'(32'h200 + i)] !== 8'(p0 + i)) bad++;
    chk("R2 captured bytes land in buffer", bad, 0);
    rd(3'd1, s);
    chk("R4 chain-end bit set", s[4], 1);
    chk("R4 channel idle at chain end", s[2], 0);
    chk("R4 irq on chain end", irq, 1);
    rd(3'd5, a);
    chk("R14 live destination is last beat", a, 32'h205);
    rd(3'd4, a);
    chk("R14 live source stays on held register", a, PER);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, s);
    chk("R11 all-ones clears status", s, 0);
    wr(3'd0, 0);
  endtask

  task automatic t_prog_err();
    logic [31:0] s;
    desc(32'h060, 32'h100, PER, 32'h060, 0);
    wr(3'd2, 32'h060);
    wr(3'd0, md(1, 0, 0, 0, 0, 0, 0, 1, 2'd0, 4'd2));
    wait_idle();
    rd(3'd1, s);
    chk("R8 zero count gives programming error", s[1:0], 2'b10);
    chk("R10 error irq masked when disabled", irq, 0);
    wr(3'd0, md(0, 0, 0, 1, 0, 0, 0, 1, 2'd0, 4'd2));
    tick(1);
    chk("R10 error irq when enabled", irq, 1);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 5);
    wr(3'd0, md(1, 0, 0, 0, 0, 1, 0, 1, 2'd0, 4'd2));
    rd(3'd1, s);
    chk("R8 pause enable with nonzero count", s[2:1], 2'b01);
    wr(3'd3, 0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 0);
  endtask

  task automatic t_xfer_err();
    logic [31:0] s;
    err_addr = 32'h10A;
    wr(3'd2, 32'h000);
    wr(3'd0, md(1, 0, 0, 1, 0, 0, 0, 1, 2'd1, 4'd4));
    wait_idle();
    rd(3'd1, s);
    chk("R9 transfer error halts channel", s[2:0], 3'b001);
    chk("R9 R10 irq on transfer error", irq, 1);
    err_addr = 32'hFFFF_FFFF;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 0);
  endtask

  task automatic t_pause();
    logic [31:0] s; int base, w1, w2;
    desc(32'h080, 32'h100, PER, 32'h080, 16);
    wr(3'd3, 0);
    wr(3'd2, 32'h080);
    ext_pause = 1'b1;
    base = nlog;
    wr(3'd0, md(1, 0, 0, 0, 0, 1, 0, 1, 2'd0, 4'd2));
    tick(40);
    rd(3'd1, s);
    chk("R6 paused before first chunk, busy", s[2], 1);
    chk("R6 no data moved while paused", nlog - base, 0);
    wr(3'd2, 32'h0A0);
    rd(3'd2, s);
    chk("R13 descriptor write ignored while busy", s, 32'h080);
    ext_pause = 1'b0;
    wait_log(base + 6);
    ext_pause = 1'b1;
    tick(40);
    w1 = nlog - base;
    tick(40);
    w2 = nlog - base;
    chk("R6 stall holds across window", w2, w1);
    chk("R6 stall lands on chunk boundary", w1 % 4, 0);
    ext_pause = 1'b0;
    wr(3'd0, md(0, 1, 0, 0, 0, 0, 0, 0, 2'd0, 4'd0));
    wr(3'd0, 0);
    wr(3'd3, 0);
  endtask

  task automatic t_ext_start();
    logic [31:0] s; logic [7:0] p0; int bad;
    desc(32'h0A0, PER, 32'h280, 32'h0A1, 4);
    wr(3'd2, 32'h0A0);
    wr(3'd0, md(1, 0, 0, 0, 1, 0, 1, 0, 2'd0, 4'd2));
    tick(20);
    rd(3'd1, s);
    chk("R7 kick ignored under external start", s[2], 0);
    p0 = pcnt;
    @(negedge clk); ext_req = 1'b1;
    @(negedge clk); ext_req = 1'b0;
    wait_idle();
    bad = 0;
    for (int i = 0; i < 4; i++) if (mem[10'(32'h280 + i)] !== 8'(p0 + i)) bad++;
    chk("R7 external request runs the chain", bad, 0);
    rd(3'd1, s);
    chk("R7 chain end after external start", s[4], 1);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_playback();
    t_capture();
    t_prog_err();
    t_xfer_err();
    t_pause();
    t_ext_start();
    tick(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule